// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Sequencer

This block is the digital control side of a 16-bit sampling converter with a serial output. It shows at its pins how such a converter answers its control lines. The control lines are a calibration request, an acquisition strobe and an external conversion clock. The outputs are a busy flag, a derived serial clock and a serial data line. The analog core is not modelled. In its place, a signed parallel test input stands for the analog value. That value is clamped to the 16-bit range and frozen when the strobe falls. The frozen code is then sent out one bit per conversion-clock pulse.

The external conversion clock and the strobe are oversampled by a faster system clock through two-stage synchronizers. All of the block's work is triggered by the edges it detects, so the outputs follow the pins with a fixed latency of a few system cycles. Every output is a register, and no combinational path runs from the conversion clock to the data line. A calibration request acts at once and aborts any activity. After the request is released, calibration runs for a fixed number of conversion-clock edges. A status flag shows that no calibration has completed since reset.

In continuous use, the strobe can be raised before the last conversion pulse and dropped as soon as busy falls. This starts the next conversion with no idle acquisition phase between the two.

Top module: `sar_adc_seq`

## Requirements
- R1: After `rst_n` is released, `busy_o`=0, `sclk_o`=1, `sdata_o`=0 and `uncal_o`=1.
- R2: Raising `cal_i` forces `busy_o`=1 and `uncal_o`=1 at once, with no system-clock edge needed, and aborts any conversion in progress.
- R3: Once `cal_i` is low, `busy_o` stays high for `CAL_CYCLES`-1 rising edges of `cnv_clk_i` and falls after edge number `CAL_CYCLES`. `uncal_o` clears at the same moment.
- R4: During calibration with `sample_i` held low, `sdata_o` stays 0. With `sample_i` high, `sdata_o` may carry arbitrary diagnostic bits.
- R5: A falling edge of `sample_i` while `busy_o`=0 freezes the clamped test input and raises `busy_o`.
- R6: While `busy_o`=1, edges on `sample_i` are ignored. The frozen code is unchanged, and no second conversion follows.
- R7: Rising edges of `cnv_clk_i` that arrive within `IGN_CYC` system cycles after the strobe fall is detected are not counted as conversion pulses.
- R8: A conversion takes 17 counted pulses. On pulses 2 to 17, `sdata_o` takes the next bit of the code, MSB first, and `sclk_o` rises one system cycle later. This gives 16 `sclk_o` rising edges. `busy_o` falls together with the 16th rise and stays high through pulse 16.
- R9: The test input is `IN_W`-bit twos complement. Values above 32767 give code 0x7FFF, values below -32768 give code 0x8000, and all other values give their own low 16 bits.
- R10: While `busy_o` stays low, `cnv_clk_i` pulses leave `sdata_o` and `sclk_o` unchanged.
- R11: If `sample_i` is high at the 17th pulse, that counts as the acquisition. A falling edge of `sample_i` after `busy_o` drops starts the next conversion with no further rising edge required.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the control lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_i | input | 1 | Calibration request; asynchronous abort while high |
| sample_i | input | 1 | Acquisition strobe; falling edge starts a conversion |
| cnv_clk_i | input | 1 | External conversion clock, one bit decided per rising edge |
| test_val_i | input | IN_W | Signed value standing in for the analog input |
| busy_o | output | 1 | High during calibration or conversion |
| sclk_o | output | 1 | Serial clock; rises once data is stable |
| sdata_o | output | 1 | Serial data, MSB first |
| uncal_o | output | 1 | High until a calibration completes |

## Verification
Some properties are checked by assertions on every cycle. Busy and the not-calibrated flag must be high while calibration is requested. The serial lines must be frozen whenever busy stays low. The serial clock may rise only while a conversion was under way. The not-calibrated flag may clear only when busy falls. The directed scenarios cover what needs a stimulus history. These are the exact calibration length, the clamping of out-of-range values, and the MSB-first bit order and pulse count. They also cover the dropped clock edges inside the ignore window, the strobe lock-out, an abort in mid-conversion, and back-to-back conversions.

// File: rtl/sar_adc_seq.sv
module sar_adc_seq #(
  parameter int DATA_W     = 16,
  parameter int IN_W       = 18,
  parameter int CAL_CYCLES = 85532,
  parameter int IGN_CYC    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cal_i,
  input  logic                   sample_i,
  input  logic                   cnv_clk_i,
  input  logic signed [IN_W-1:0] test_val_i,
  output logic                   busy_o,
  output logic                   sclk_o,
  output logic                   sdata_o,
  output logic                   uncal_o
);

  localparam int NPULSE = DATA_W + 1;
  localparam int M1     = (CAL_CYCLES > IGN_CYC) ? CAL_CYCLES : IGN_CYC;
  localparam int CMAX   = (M1 > NPULSE) ? M1 : NPULSE;
  localparam int CW     = $clog2(CMAX + 1);
  localparam logic signed [IN_W-1:0] POS_FS = IN_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [IN_W-1:0] NEG_FS = ~POS_FS;

  typedef enum logic [1:0] {S_IDLE, S_CAL, S_IGN, S_CONV} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] res;
  logic              pend;
  logic [2:0]        ck_sy, sm_sy;
  logic              clk_rise, smp_fall;
  logic [DATA_W-1:0] clamped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ck_sy <= '0;
      sm_sy <= '0;
    end else begin
      ck_sy <= {ck_sy[1:0], cnv_clk_i};
      sm_sy <= {sm_sy[1:0], sample_i};
    end

  assign clk_rise = ck_sy[1] & ~ck_sy[2];
  assign smp_fall = sm_sy[2] & ~sm_sy[1];

  assign clamped = (test_val_i > POS_FS) ? POS_FS[DATA_W-1:0] :
                   (test_val_i < NEG_FS) ? NEG_FS[DATA_W-1:0] :
                   test_val_i[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n or posedge cal_i)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      res     <= '0;
      pend    <= 1'b0;
      busy_o  <= 1'b0;
      sclk_o  <= 1'b1;
      sdata_o <= 1'b0;
      uncal_o <= 1'b1;
    end else if (cal_i) begin
      st      <= S_CAL;
      cnt     <= '0;
      res     <= '0;
      pend    <= 1'b0;
      busy_o  <= 1'b1;
      sclk_o  <= 1'b1;
      sdata_o <= 1'b0;
      uncal_o <= 1'b1;
    end else begin
      pend <= 1'b0;
      case (st)
        S_IDLE:
          if (smp_fall) begin
            res    <= clamped;
            busy_o <= 1'b1;
            cnt    <= '0;
            st     <= S_IGN;
          end
        S_CAL:
          if (clk_rise) begin
            if (sm_sy[1]) sdata_o <= cnt[0];
            if (cnt == CW'(CAL_CYCLES - 1)) begin
              busy_o  <= 1'b0;
              uncal_o <= 1'b0;
              sdata_o <= 1'b0;
              cnt     <= '0;
              st      <= S_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        S_IGN:
          if (cnt == CW'(IGN_CYC - 1)) begin
            cnt <= '0;
            st  <= S_CONV;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: begin
          if (pend) begin
            sclk_o <= 1'b1;
            if (cnt == CW'(NPULSE)) begin
              busy_o <= 1'b0;
              st     <= S_IDLE;
            end
          end else if (clk_rise) begin
            cnt <= cnt + 1'b1;
            if (cnt != '0) begin
              sdata_o <= res[DATA_W-1];
              res     <= {res[DATA_W-2:0], 1'b0};
              sclk_o  <= 1'b0;
              pend    <= 1'b1;
            end
          end
        end
      endcase
    end

  // R2
  busy_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cal_i |-> (busy_o && uncal_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    (!busy_o && $past(!busy_o)) |-> ($stable(sdata_o) && $stable(sclk_o)));

  // R8
  sclk_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    $rose(sclk_o) |-> $past(busy_o));

  // R3
  uncal_clear_chk: assert property (@(posedge clk) disable iff (!rst_n || cal_i)
    $fell(uncal_o) |-> $fell(busy_o));

endmodule

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;
  localparam int CALN = 50;
  localparam int IGN  = 8;

  logic clk = 1'b0, rst_n = 1'b0, cal = 1'b0, sample = 1'b0, cnv = 1'b0;
  logic signed [17:0] tv = '0;
  logic busy, sclk, sdata, uncal;
  int checks = 0, fails = 0, sclk_rises = 0;

  always #4 clk = ~clk;
  always @(posedge sclk) sclk_rises++;

  sar_adc_seq #(.DATA_W(16), .IN_W(18), .CAL_CYCLES(CALN), .IGN_CYC(IGN)) u_dut (
    .clk(clk), .rst_n(rst_n), .cal_i(cal), .sample_i(sample), .cnv_clk_i(cnv),
    .test_val_i(tv), .busy_o(busy), .sclk_o(sclk), .sdata_o(sdata), .uncal_o(uncal));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnv = 1'b1; wait_n(4);
    cnv = 1'b0; wait_n(4);
  endtask

  function automatic logic [15:0] exp_code(int v);
    if (v > 32767) return 16'h7FFF;
    if (v < -32768) return 16'h8000;
    return 16'(v);
  endfunction

  task automatic start_conv(int v);
    tv = 18'(v);
    sample = 1'b1; wait_n(6);
    sample = 1'b0; wait_n(IGN + 6);
  endtask

  task automatic finish_pulses(int first, inout logic [15:0] got);
    for (int k = first; k <= 17; k++) begin
      pulse();
      if (k >= 2) got = {got[14:0], sdata};
      if (k == 16) chk("R8 busy through pulse 16", busy, 1);
    end
  endtask

  task automatic do_conv(int v, string tag);
    logic [15:0] got = '0;
    start_conv(v);
    chk({tag, " R5 busy after strobe fall"}, busy, 1);
    sclk_rises = 0;
    finish_pulses(1, got);
    chk({tag, " R9 code"}, got, exp_code(v));
    chk({tag, " R8 sclk rises"}, sclk_rises, 16);
    chk({tag, " R8 busy low after pulse 17"}, busy, 0);
  endtask

  task automatic t_reset();
    wait_n(3); rst_n = 1'b1; wait_n(3);
    chk("R1 busy", busy, 0);
    chk("R1 sclk", sclk, 1);
    chk("R1 sdata", sdata, 0);
    chk("R1 uncal", uncal, 1);
  endtask

  task automatic t_calibrate();
    logic sd_bad = 1'b0;
    cal = 1'b1; #1;
    chk("R2 busy asynchronous", busy, 1);
    wait_n(4); cal = 1'b0; wait_n(4);
    for (int k = 1; k < CALN; k++) begin
      pulse();
      if (sdata !== 1'b0) sd_bad = 1'b1;
    end
    chk("R3 busy before last edge", busy, 1);
    chk("R3 uncal before last edge", uncal, 1);
    chk("R4 sdata quiet in cal", sd_bad, 0);
    pulse();
    chk("R3 busy after last edge", busy, 0);
    chk("R3 uncal cleared", uncal, 0);
  endtask

  task automatic t_ignore_window();
    logic [15:0] got = '0;
    tv = 18'sh05A3;
    sample = 1'b1; wait_n(6);
    sample = 1'b0; wait_n(1);
    cnv = 1'b1; wait_n(2); cnv = 1'b0; wait_n(IGN + 6);
    sclk_rises = 0;
    finish_pulses(1, got);
    chk("R7 early edge ignored, code", got, 16'h05A3);
    chk("R7 busy low after 17 counted", busy, 0);
  endtask

  task automatic t_lockout();
    logic [15:0] got = '0;
    start_conv(-12345);
    finish_pulses(1, got);
    got = '0;
    start_conv(4660);
    for (int k = 1; k <= 5; k++) begin
      pulse();
      if (k >= 2) got = {got[14:0], sdata};
    end
    tv = 18'sh00F0;
    sample = 1'b1; wait_n(6); sample = 1'b0; wait_n(6);
    finish_pulses(6, got);
    chk("R6 code unchanged by strobe", got, 16'h1234);
    wait_n(20);
    chk("R6 no second conversion", busy, 0);
  endtask

  task automatic t_hold();
    logic sd0, sc0;
    sd0 = sdata; sc0 = sclk;
    sclk_rises = 0;
    pulse(); pulse(); pulse();
    chk("R10 sdata held", sdata, sd0);
    chk("R10 sclk held", sclk, sc0);
    chk("R10 no sclk rise", sclk_rises, 0);
    chk("R10 busy stays low", busy, 0);
  endtask

  task automatic t_continuous();
    logic [15:0] got = '0;
    start_conv(100);
    for (int k = 1; k <= 15; k++) begin
      pulse();
      if (k >= 2) got = {got[14:0], sdata};
    end
    tv = -18'sd200;
    sample = 1'b1;
    finish_pulses(16, got);
    chk("R11 first code", got, 16'd100);
    chk("R11 busy low with strobe high", busy, 0);
    sample = 1'b0; wait_n(6);
    chk("R11 busy after direct fall", busy, 1);
    wait_n(IGN + 2);
    got = '0;
    finish_pulses(1, got);
    chk("R11 second code", got, 16'hFF38);
  endtask

  task automatic t_abort();
    start_conv(7);
    pulse(); pulse(); pulse();
    cal = 1'b1; #1;
    chk("R2 abort busy", busy, 1);
    chk("R2 abort uncal", uncal, 1);
    wait_n(4); cal = 1'b0; wait_n(4);
    for (int k = 1; k <= CALN; k++) pulse();
    chk("R3 recal done", busy, 0);
    chk("R3 recal uncal", uncal, 0);
  endtask

  initial begin
    t_reset();
    t_calibrate();
    do_conv(4660, "basic");
    do_conv(131071, "clamp high");
    do_conv(-40000, "clamp low");
    do_conv(32767, "pos edge");
    do_conv(-32768, "neg edge");
    do_conv(-1, "minus one");
    t_ignore_window();
    t_lockout();
    t_hold();
    t_continuous();
    t_abort();
    do_conv(-21846, "after recal");
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end
endmodule